// File: doc/BRIEF.md
# Reactive Await Sequencer

This block sits beside the fetch stage of a small reactive processor core and handles every instruction that waits. It supports four waiting forms: a wait for a fixed number of instruction cycles, a wait for one named input signal, a wait for either of two named signals that ends in a two-way branch, and a halt. While a wait is in progress the block holds the fetch stage with a stall output. When the wait finishes it releases the stall. For the two-signal form it also reports whether execution continues in sequence or jumps to an alternative address. That address is stored beforehand by a separate load-address operation.

Each waiting instruction also ends the current logical tick. A logical tick therefore lasts as long as the instantaneous code between two waits takes to run. The block marks each tick boundary with a one-cycle strobe, which the rest of the core uses to clear emitted signals and to evaluate pending aborts. It also keeps a running count of completed ticks. Waits are never immediate: a signal that is already present in the cycle the wait is issued does not end it. An abort redirect from elsewhere in the core cancels any wait at once.

Top module: `reactive_await_seq`

## Requirements
- R1: After reset, stall_o, branch_o and tick_o are low and tick_cnt_o is zero.
- R2: An accepted wait of any kind drives tick_o high for exactly the one cycle after issue. tick_cnt_o increments in that same cycle and wraps modulo 2^TICK_W.
- R3: A timed wait (kind 2'b01) holds stall_o high for exactly count_i cycles, starting the cycle after issue. A count of zero behaves as a count of one.
- R4: A single-signal wait (kind 2'b10) holds stall_o until sig_i[sel_a_i] is sampled high in a cycle after issue. stall_o drops in the following cycle.
- R5: Signals that are present only in the issue cycle do not end any wait.
- R6: A two-signal wait (kind 2'b11) ends on sig_i[sel_a_i] with branch_o low, or on sig_i[sel_b_i] with branch_o high. On a branch, branch_o is high for one cycle, in the first cycle with stall_o low, and target_o then shows the stored alternative address.
- R7: If both signals of a two-signal wait arrive in the same cycle, the first signal wins and branch_o stays low.
- R8: A pulse on ld_i stores ld_addr_i as the alternative address. The most recent load before the branch decision is the one used.
- R9: redirect_i cancels any wait: stall_o is low in the next cycle and no branch is reported. An issue in the same cycle as redirect_i is dropped, with no tick.
- R10: An issue while stall_o is high is ignored. It produces no tick and does not change the wait in progress.
- R11: A halt (kind 2'b00) ends the tick and holds stall_o high until redirect_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| start_i | input | 1 | Issue of a decoded wait instruction |
| kind_i | input | 2 | Wait kind: 00 halt, 01 timed, 10 one signal, 11 either signal |
| count_i | input | CNT_W | Cycle count for a timed wait |
| sel_a_i | input | SEL_W | Index of the first (or only) awaited signal |
| sel_b_i | input | SEL_W | Index of the second awaited signal |
| ld_i | input | 1 | Store the alternative branch address |
| ld_addr_i | input | ADDR_W | Alternative address to store |
| sig_i | input | NUM_SIG | Input signal vector |
| redirect_i | input | 1 | Abort redirect; cancels any wait |
| stall_o | output | 1 | Hold the fetch stage |
| branch_o | output | 1 | Two-signal wait ended on the second signal |
| target_o | output | ADDR_W | Branch target, valid with branch_o |
| tick_o | output | 1 | Logical tick boundary strobe |
| tick_cnt_o | output | TICK_W | Count of completed logical ticks |

## Verification
The bench uses 16 signals, an 8-bit cycle count and 13-bit addresses. It narrows the tick counter to 4 bits, so the run issues enough waits to reach the counter's wrap from 15 back to 0. The 8-bit count allows a timed wait of 200 cycles as well as the zero-count boundary. With 16 signals, the index extremes 0 and 15 both fall within the vector table. Every wait is issued with its own awaited signals already high in the issue cycle, so any early release shows up as a wrong stall length.

// File: rtl/await_seq_pkg.sv
package await_seq_pkg;

    typedef enum logic [1:0] {
        AW_HALT   = 2'b00,
        AW_TIME   = 2'b01,
        AW_SIG    = 2'b10,
        AW_EITHER = 2'b11
    } aw_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_TIME,
        ST_SIG,
        ST_EITHER
    } aw_state_e;

endpackage

// File: rtl/await_sig_pick.sv
module await_sig_pick #(
    parameter int NUM_SIG = 16,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SIG-1:0] sig_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);

    always_comb begin
        hit_o = 1'b0;
        for (int k = 0; k < NUM_SIG; k++) begin
            if (sel_i == SEL_W'(k)) begin
                hit_o = sig_i[k];
            end
        end
    end

endmodule

// File: rtl/await_delay_cnt.sv
module await_delay_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            // a zero count is promoted to a single cycle
            cnt_d = (load_val_i == '0) ? CNT_W'(1) : load_val_i;
        end else if (run_i && (cnt_q > CNT_W'(1))) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/await_tick_ctr.sv
module await_tick_ctr #(
    parameter int TICK_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    output logic [TICK_W-1:0] cnt_o
);

    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d = cnt_q + TICK_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/reactive_await_seq.sv
module reactive_await_seq
    import await_seq_pkg::*;
#(
    parameter int NUM_SIG = 16,
    parameter int CNT_W   = 8,
    parameter int ADDR_W  = 13,
    parameter int TICK_W  = 16,
    localparam int SEL_W  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [SEL_W-1:0]  sel_a_i,
    input  logic [SEL_W-1:0]  sel_b_i,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [NUM_SIG-1:0] sig_i,
    input  logic              redirect_i,
    output logic              stall_o,
    output logic              branch_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              tick_o,
    output logic [TICK_W-1:0] tick_cnt_o
);

    localparam int NUM_SEL = 2;

    typedef struct packed {
        aw_state_e         st;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic [ADDR_W-1:0] alt;
        logic [ADDR_W-1:0] tgt;
        logic              tick;
        logic              br;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             accept;
    logic             time_last;
    logic [NUM_SEL-1:0] hit;
    logic [SEL_W-1:0] sel_arr [NUM_SEL];

    assign sel_arr[0] = s_q.sel_a;
    assign sel_arr[1] = s_q.sel_b;

    // one selector per awaited signal slot
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_pick
        await_sig_pick #(
            .NUM_SIG (NUM_SIG),
            .SEL_W   (SEL_W)
        ) u_pick (
            .sig_i (sig_i),
            .sel_i (sel_arr[g]),
            .hit_o (hit[g])
        );
    end

    assign accept = start_i && (s_q.st == ST_IDLE) && !redirect_i;

    await_delay_cnt #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (accept && (aw_kind_e'(kind_i) == AW_TIME)),
        .load_val_i (count_i),
        .run_i      (s_q.st == ST_TIME),
        .last_o     (time_last)
    );

    await_tick_ctr #(
        .TICK_W (TICK_W)
    ) u_ticks (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (accept),
        .cnt_o  (tick_cnt_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        s_d.br   = 1'b0;
        if (ld_i) begin
            s_d.alt = ld_addr_i;
        end
        if (redirect_i) begin
            s_d.st = ST_IDLE;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        s_d.tick  = 1'b1;
                        s_d.sel_a = sel_a_i;
                        s_d.sel_b = sel_b_i;
                        unique case (aw_kind_e'(kind_i))
                            AW_HALT:   s_d.st = ST_HALT;
                            AW_TIME:   s_d.st = ST_TIME;
                            AW_SIG:    s_d.st = ST_SIG;
                            AW_EITHER: s_d.st = ST_EITHER;
                            default:   s_d.st = ST_HALT;
                        endcase
                    end
                end
                ST_TIME: begin
                    if (time_last) begin
                        s_d.st = ST_IDLE;
                    end
                end
                ST_SIG: begin
                    if (hit[0]) begin
                        s_d.st = ST_IDLE;
                    end
                end
                ST_EITHER: begin
                    // first slot has precedence over the second
                    if (hit[0]) begin
                        s_d.st = ST_IDLE;
                    end else if (hit[1]) begin
                        s_d.st  = ST_IDLE;
                        s_d.br  = 1'b1;
                        s_d.tgt = ld_i ? ld_addr_i : s_q.alt;
                    end
                end
                ST_HALT: begin
                    s_d.st = ST_HALT;
                end
                default: begin
                    s_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign stall_o  = (s_q.st != ST_IDLE);
    assign branch_o = s_q.br;
    assign target_o = s_q.tgt;
    assign tick_o   = s_q.tick;

endmodule

// File: rtl/await_seq_chk.sv
module await_seq_chk #(
    parameter int TICK_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              redirect_i,
    input logic              stall_o,
    input logic              branch_o,
    input logic              tick_o,
    input logic [TICK_W-1:0] tick_cnt_o
);

    logic [TICK_W-1:0] prev_cnt_q;
    logic [TICK_W-1:0] inc_cnt;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_cnt_q <= '0;
        end else begin
            prev_cnt_q <= tick_cnt_o;
        end
    end

    assign inc_cnt = prev_cnt_q + TICK_W'(1);

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!stall_o && !tick_o && !branch_o)); // R1

    AST_ISSUE_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !stall_o && !redirect_i) |=> (tick_o && stall_o)); // R2

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2

    AST_TICK_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (tick_cnt_o == inc_cnt)); // R2

    AST_TICK_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |-> (tick_cnt_o == prev_cnt_q)); // R2

    AST_BRANCH_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_o |-> (!stall_o && $past(stall_o))); // R6

    AST_REDIRECT_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_i |=> (!stall_o && !branch_o && !tick_o)); // R9

    AST_BUSY_ISSUE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && stall_o) |=> !tick_o); // R10

endmodule

bind reactive_await_seq await_seq_chk #(
    .TICK_W (TICK_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .redirect_i (redirect_i),
    .stall_o    (stall_o),
    .branch_o   (branch_o),
    .tick_o     (tick_o),
    .tick_cnt_o (tick_cnt_o)
);

// File: tb/reactive_await_seq_tb_top.sv
module reactive_await_seq_tb_top;

    localparam int NUM_SIG = 16;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 13;
    localparam int TICK_W  = 4;
    localparam int SEL_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        kind = '0;
    logic [CNT_W-1:0]  count = '0;
    logic [SEL_W-1:0]  sel_a = '0;
    logic [SEL_W-1:0]  sel_b = '0;
    logic              ld = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [NUM_SIG-1:0] sig = '0;
    logic              redirect = 1'b0;
    logic              stall;
    logic              branch;
    logic [ADDR_W-1:0] target;
    logic              tick;
    logic [TICK_W-1:0] tick_cnt;

    int tests = 0;
    int fails = 0;
    int exp_ticks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    reactive_await_seq #(
        .NUM_SIG (NUM_SIG),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .TICK_W  (TICK_W)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .kind_i     (kind),
        .count_i    (count),
        .sel_a_i    (sel_a),
        .sel_b_i    (sel_b),
        .ld_i       (ld),
        .ld_addr_i  (ld_addr),
        .sig_i      (sig),
        .redirect_i (redirect),
        .stall_o    (stall),
        .branch_o   (branch),
        .target_o   (target),
        .tick_o     (tick),
        .tick_cnt_o (tick_cnt)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  cnt;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [15:0] mask;
        logic [7:0]  fire_at;
        logic [7:0]  exp_len;
        logic        exp_br;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 8'd3,   4'd0,  4'd0, 16'h0000, 8'd0, 8'd3,   1'b0, 4'd3}, // R3 plain count
        '{2'b01, 8'd0,   4'd0,  4'd0, 16'h0000, 8'd0, 8'd1,   1'b0, 4'd3}, // R3 zero count
        '{2'b01, 8'd1,   4'd0,  4'd0, 16'h0000, 8'd0, 8'd1,   1'b0, 4'd3}, // R3 count one
        '{2'b10, 8'd0,   4'd5,  4'd5, 16'h0020, 8'd4, 8'd4,   1'b0, 4'd4}, // R4 / R5
        '{2'b10, 8'd0,   4'd0,  4'd0, 16'h0001, 8'd1, 8'd1,   1'b0, 4'd4}, // R4 lowest index
        '{2'b11, 8'd0,   4'd2,  4'd9, 16'h0004, 8'd3, 8'd3,   1'b0, 4'd6}, // R6 first signal
        '{2'b11, 8'd0,   4'd2,  4'd15,16'h8000, 8'd2, 8'd2,   1'b1, 4'd6}, // R6 second signal, top index
        '{2'b11, 8'd0,   4'd3,  4'd7, 16'h0088, 8'd2, 8'd2,   1'b0, 4'd7}, // R7 both together
        '{2'b01, 8'd200, 4'd0,  4'd0, 16'h0000, 8'd0, 8'd200, 1'b0, 4'd3}  // R3 long count
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [CNT_W-1:0] c,
                         input logic [SEL_W-1:0] a, input logic [SEL_W-1:0] b,
                         input logic [NUM_SIG-1:0] pre);
        @(negedge clk);
        start = 1'b1;
        kind  = k;
        count = c;
        sel_a = a;
        sel_b = b;
        sig   = pre;
        @(negedge clk);
        start = 1'b0;
        sig   = '0;
    endtask

    task automatic load_addr(input logic [ADDR_W-1:0] addr);
        @(negedge clk);
        ld      = 1'b1;
        ld_addr = addr;
        @(negedge clk);
        ld      = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input logic [ADDR_W-1:0] exp_tgt);
        logic [NUM_SIG-1:0] pre;
        int i;
        string rq;
        rq  = $sformatf("R%0d", v.req);
        pre = (v.kind == 2'b01) ? '0 : ((NUM_SIG'(1) << v.a) | (NUM_SIG'(1) << v.b));
        issue(v.kind, v.cnt, v.a, v.b, pre);
        exp_ticks++;
        check(tick == 1'b1, "R2", "tick strobe after issue", int'(tick), 1);
        check(int'(tick_cnt) == (exp_ticks % 16), "R2", "tick count", int'(tick_cnt), exp_ticks % 16);
        i = 1;
        while (stall && i < 1000) begin
            if (i == int'(v.fire_at)) sig = v.mask;
            @(negedge clk);
            i++;
        end
        check((i - 1) == int'(v.exp_len), rq, "stall length (R5 issue-cycle signals ignored)",
              i - 1, int'(v.exp_len));
        check(branch == v.exp_br, rq, "branch flag", int'(branch), int'(v.exp_br));
        if (v.exp_br) begin
            check(target == exp_tgt, "R6", "branch target", int'(target), int'(exp_tgt));
        end
        sig = '0;
        @(negedge clk);
        check(branch == 1'b0, rq, "branch flag one cycle only", int'(branch), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);
        check(tick == 1'b0, "R1", "tick after reset", int'(tick), 0);
        check(branch == 1'b0, "R1", "branch after reset", int'(branch), 0);
        check(tick_cnt == '0, "R1", "tick count after reset", int'(tick_cnt), 0);

        load_addr(13'h0A5);
        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k], 13'h0A5);
        end

        // R8 the most recent load is used
        load_addr(13'h111);
        load_addr(13'h0F0);
        run_vec('{2'b11, 8'd0, 4'd1, 4'd4, 16'h0010, 8'd2, 8'd2, 1'b1, 4'd8}, 13'h0F0);
        check(target == 13'h0F0, "R8", "latest loaded address", int'(target), 13'h0F0);

        // R9 redirect cancels a timed wait
        issue(2'b01, 8'd50, '0, '0, '0);
        exp_ticks++;
        repeat (2) @(negedge clk);
        redirect = 1'b1;
        @(negedge clk);
        redirect = 1'b0;
        check(stall == 1'b0, "R9", "stall dropped after redirect", int'(stall), 0);

        // R9 redirect wins over a second-signal arrival
        issue(2'b11, 8'd0, 4'd0, 4'd1, '0);
        exp_ticks++;
        sig      = 16'h0002;
        redirect = 1'b1;
        @(negedge clk);
        redirect = 1'b0;
        sig      = '0;
        check(branch == 1'b0, "R9", "no branch under redirect", int'(branch), 0);
        check(stall == 1'b0, "R9", "stall low under redirect", int'(stall), 0);

        // R9 issue together with redirect is dropped
        @(negedge clk);
        start    = 1'b1;
        kind     = 2'b01;
        count    = 8'd4;
        redirect = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        redirect = 1'b0;
        check(tick == 1'b0, "R9", "no tick for dropped issue", int'(tick), 0);
        check(stall == 1'b0, "R9", "no stall for dropped issue", int'(stall), 0);
        check(int'(tick_cnt) == (exp_ticks % 16), "R9", "tick count unchanged",
              int'(tick_cnt), exp_ticks % 16);

        // R10 issue while stalled is ignored
        issue(2'b01, 8'd5, '0, '0, '0);
        exp_ticks++;
        start = 1'b1;
        kind  = 2'b01;
        count = 8'd60;
        @(negedge clk);
        start = 1'b0;
        check(tick == 1'b0, "R10", "no tick for busy issue", int'(tick), 0);
        n = 2;
        while (stall && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check((n - 1) == 5, "R10", "original wait length kept", n - 1, 5);

        // R11 halt holds until redirect
        issue(2'b00, '0, 4'd3, 4'd3, 16'hFFFF);
        exp_ticks++;
        check(tick == 1'b1, "R11", "halt ends the tick", int'(tick), 1);
        sig = 16'hFFFF;
        repeat (20) @(negedge clk);
        sig = '0;
        check(stall == 1'b1, "R11", "halt still stalled", int'(stall), 1);
        redirect = 1'b1;
        @(negedge clk);
        redirect = 1'b0;
        check(stall == 1'b0, "R11", "halt released by redirect", int'(stall), 0);

        // R2 tick counter wrap over 4 bits
        for (int k = 0; k < 6; k++) begin
            issue(2'b01, 8'd1, '0, '0, '0);
            exp_ticks++;
            check(int'(tick_cnt) == (exp_ticks % 16), "R2", "tick count across wrap",
                  int'(tick_cnt), exp_ticks % 16);
            @(negedge clk);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule